// File: doc/BRIEF.md
# SMBus Pointer Register Interface

This block is the serial-bus front end of a temperature-monitoring slave. It listens on the SCL and SDA lines, which it samples with the system clock, and it pulls SDA low through an open-drain enable. An 8-bit pointer register picks one of eight 16-bit registers:

| Pointer low bits | Register |
|---|---|
| 0 | capability |
| 1 | configuration |
| 2 | upper alarm limit |
| 3 | lower alarm limit |
| 4 | critical limit |
| 5 | temperature |
| 6 | manufacturer ID |
| 7 | device ID |

A master can do three kinds of transfer. It can write the pointer alone. It can write the pointer followed by a 16-bit value. It can read 16 bits, either from the pointer it last wrote, or after writing the pointer and then issuing a repeated start.

The configuration fields and the three limits are brought out as ports so that neighbouring logic can use them. The temperature word is an input from the converter. A busy flag shows when the bus is between a start and a stop. Two lock bits guard the limits and the event settings; once set, they are cleared only by reset. If SDA stays still for too long in the middle of a transfer, the interface gives up. Electrical filtering is reduced to a synchronizer.

Top module: `smb_ptr_regfile`

## Requirements
- R1: The device answers the 7-bit address formed by 4'b0011 in the high bits and the three address-pin levels in the low bits (0x18 to 0x1F). It drives ACK low in the ninth clock of a matching address byte. A byte with any other address gets no ACK, and SDA is never driven during it.
- R2: After reset the pointer is 0x00, so a read with no pointer write returns the capability word. The pointer keeps its last written value across transfers, and only its low three bits choose the register.
- R3: A register write is the address byte, then the pointer byte, then two data bytes, most significant first. Bytes after the second data byte are acknowledged but change nothing.
- R4: A read returns two bytes, high byte first, from the pointer. A pointer write followed by a repeated start and a read address also returns the selected register.
- R5: The master may answer the second read byte with ACK or NACK. Either way the device releases SDA after that byte and the transfer ends at the stop.
- R6: Reset values are: capability 0x001D, configuration 0x0000, each limit 0x0000, manufacturer ID 0x11D4, device ID 0x0801.
- R7: If SDA does not change for TIMEOUT_CYCLES clocks while a transfer is in progress, the interface releases SDA, clears the busy flag and waits for a new start.
- R8: The address pins are captured when the R/W bit of the second matching address byte after reset is received. After that, pin changes have no effect on which address matches.
- R9: Each limit register stores only bits 12 to 2 (sign and ten bits, 0.25 degree per LSB). All other bits read back as 0.
- R10: While the alarm lock (configuration bit 6) is set, writes to the upper and lower limits are ignored. While the critical lock (bit 7) is set, writes to the critical limit are ignored.
- R11: Once set, each lock stays set until reset. While either lock is set, the event bits (bit 0 mode, bit 1 polarity, bit 2 critical-only, bit 3 enable) are frozen, and shutdown (bit 8) cannot be set, though it can still be cleared. Hysteresis (bits 10:9) stays writable.
- R12: Configuration bit 5 (clear-event) and bit 4 (event status) always read as 0.
- R13: Writes to the capability, temperature and ID registers are acknowledged and discarded.
- R14: busBusy goes high at a start condition and low at a stop condition or a timeout. SDA is never driven while busBusy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock level from the bus |
| sdaIn | input | 1 | Serial data level from the bus |
| addrPins | input | 3 | Address-select pin levels |
| tempValue | input | 16 | Temperature word returned at pointer 5 |
| sdaOe | output | 1 | 1 pulls SDA low |
| busBusy | output | 1 | Transfer in progress |
| evtMode | output | 1 | Configuration bit 0 |
| evtPol | output | 1 | Configuration bit 1 |
| critOnly | output | 1 | Configuration bit 2 |
| evtEnable | output | 1 | Configuration bit 3 |
| alarmLock | output | 1 | Configuration bit 6 |
| critLock | output | 1 | Configuration bit 7 |
| shutdown | output | 1 | Configuration bit 8 |
| hyst | output | 2 | Configuration bits 10:9 |
| upperLim | output | 16 | Upper alarm limit |
| lowerLim | output | 16 | Lower alarm limit |
| critLim | output | 16 | Critical limit |

## Verification
The bound checker checks these rules on every cycle:
- The stored limits never hold bits outside 12 to 2.
- A set lock keeps its guarded limits and event bits unchanged, stays set itself, and keeps shutdown from rising.
- SDA is not driven while the bus is idle.

Only the bench scenarios can show the bus-level behaviours: address matching and pin freezing, byte order, the repeated-start read, the handling of extra and read-only writes, and recovery after an SDA timeout. Each of these depends on a whole sequence of serial bits, not on a relation that holds from one cycle to the next.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef struct packed {
    logic        ptrWr;
    logic        regWr;
    logic [15:0] data;
  } smbStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK, ST_PTR, ST_WDATA, ST_RDATA, ST_RACK
  } smbState_t;

  localparam logic [3:0]  ADDR_PREFIX = 4'b0011;
  localparam logic [15:0] LIM_MASK    = 16'h1FFC;

  localparam logic [2:0] SEL_CAP  = 3'd0;
  localparam logic [2:0] SEL_CFG  = 3'd1;
  localparam logic [2:0] SEL_UPR  = 3'd2;
  localparam logic [2:0] SEL_LWR  = 3'd3;
  localparam logic [2:0] SEL_CRIT = 3'd4;
  localparam logic [2:0] SEL_TEMP = 3'd5;
  localparam logic [2:0] SEL_MFR  = 3'd6;
  localparam logic [2:0] SEL_DEV  = 3'd7;
endpackage

// File: rtl/smb_bus_ctrl.sv
module smb_bus_ctrl
  import smb_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int TIMEOUT_CYCLES = 15_000_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [2:0]  addrPins,
  input  logic [15:0] rdData,
  output smbStrobe_t  strobe,
  output logic        sdaOe,
  output logic        busBusy
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclNow, sdaNow, sclQ, sdaQ;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
          sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
        end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= sclIn;
          sdaSync <= sdaIn;
        end
    end
  endgenerate

  assign sclNow = sclSync[SYNC_STAGES-1];
  assign sdaNow = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclNow;
      sdaQ <= sdaNow;
    end

  logic sclRise, sclFall, startCond, stopCond;
  assign sclRise   = sclNow & ~sclQ;
  assign sclFall   = ~sclNow & sclQ;
  assign startCond = sclNow & sclQ & sdaQ & ~sdaNow;
  assign stopCond  = sclNow & sclQ & ~sdaQ & sdaNow;

  smbState_t state, retSt;
  logic [TW-1:0] idleCnt;
  logic          timeoutHit;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) idleCnt <= '0;
    else if (state == ST_IDLE || (sdaNow ^ sdaQ)) idleCnt <= '0;
    else if (!timeoutHit) idleCnt <= idleCnt + 1'b1;

  assign timeoutHit = (idleCnt == TW'(TIMEOUT_CYCLES));

  logic [3:0]  bitCnt;
  logic [7:0]  rxShift, hiByte;
  logic [15:0] txShift;
  logic [1:0]  byteCnt;
  logic        ackPh, rdSel, seenOnce, frozen;
  logic [2:0]  pinLatch, effPins;
  logic [7:0]  rxByte;
  logic        addrHit, byteDone;

  assign effPins  = frozen ? pinLatch : addrPins;
  assign rxByte   = {rxShift[6:0], sdaNow};
  assign addrHit  = (rxByte[7:1] == {ADDR_PREFIX, effPins});
  assign byteDone = sclRise && (bitCnt == 4'd7);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      state    <= ST_IDLE;
      retSt    <= ST_IDLE;
      bitCnt   <= '0;
      rxShift  <= '0;
      hiByte   <= '0;
      txShift  <= '0;
      byteCnt  <= '0;
      ackPh    <= 1'b0;
      rdSel    <= 1'b0;
      seenOnce <= 1'b0;
      frozen   <= 1'b0;
      pinLatch <= '0;
      sdaOe    <= 1'b0;
      busBusy  <= 1'b0;
      strobe   <= '0;
    end else begin
      strobe <= '0;
      if (startCond) begin
        state   <= ST_ADDR;
        bitCnt  <= '0;
        byteCnt <= '0;
        ackPh   <= 1'b0;
        sdaOe   <= 1'b0;
        busBusy <= 1'b1;
      end else if (stopCond || timeoutHit) begin
        state   <= ST_IDLE;
        sdaOe   <= 1'b0;
        busBusy <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (sclRise) begin
              rxShift <= rxByte;
              bitCnt  <= bitCnt + 4'd1;
            end
            if (byteDone) begin
              bitCnt <= '0;
              if (state == ST_ADDR) begin
                if (addrHit) begin
                  if (!frozen) begin
                    if (seenOnce) begin
                      frozen   <= 1'b1;
                      pinLatch <= addrPins;
                    end else seenOnce <= 1'b1;
                  end
                  state <= ST_ACK;
                  retSt <= rxByte[0] ? ST_RDATA : ST_PTR;
                end else state <= ST_IDLE;
              end else if (state == ST_PTR) begin
                strobe.ptrWr <= 1'b1;
                strobe.data  <= {8'h00, rxByte};
                state        <= ST_ACK;
                retSt        <= ST_WDATA;
              end else begin
                state <= ST_ACK;
                retSt <= ST_WDATA;
                if (byteCnt == 2'd0) begin
                  hiByte  <= rxByte;
                  byteCnt <= 2'd1;
                end else if (byteCnt == 2'd1) begin
                  strobe.regWr <= 1'b1;
                  strobe.data  <= {hiByte, rxByte};
                  byteCnt      <= 2'd2;
                end
              end
            end
          end
          ST_ACK: if (sclFall) begin
            if (!ackPh) begin
              sdaOe <= 1'b1;
              ackPh <= 1'b1;
            end else begin
              ackPh  <= 1'b0;
              state  <= retSt;
              bitCnt <= '0;
              if (retSt == ST_RDATA) begin
                sdaOe   <= ~rdData[15];
                txShift <= {rdData[14:0], 1'b0};
                rdSel   <= 1'b0;
              end else sdaOe <= 1'b0;
            end
          end
          ST_RDATA: begin
            if (sclRise) bitCnt <= bitCnt + 4'd1;
            if (sclFall) begin
              if (bitCnt == 4'd8) begin
                sdaOe  <= 1'b0;
                state  <= ST_RACK;
                bitCnt <= '0;
              end else begin
                sdaOe   <= ~txShift[15];
                txShift <= {txShift[14:0], 1'b0};
              end
            end
          end
          ST_RACK: if (sclFall) begin
            if (!rdSel) begin
              rdSel   <= 1'b1;
              state   <= ST_RDATA;
              sdaOe   <= ~txShift[15];
              txShift <= {txShift[14:0], 1'b0};
            end else state <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
endmodule

// File: rtl/smb_reg_dp.sv
module smb_reg_dp
  import smb_pkg::*;
#(
  parameter logic [15:0] CAP_VALUE = 16'h001D,
  parameter logic [15:0] MFR_ID    = 16'h11D4,
  parameter logic [15:0] DEV_ID    = 16'h0801
) (
  input  logic        clk,
  input  logic        rstN,
  input  smbStrobe_t  strobe,
  input  logic [15:0] tempValue,
  output logic [15:0] rdData,
  output logic [3:0]  cfgEvt,
  output logic        alarmLock,
  output logic        critLock,
  output logic        shutdown,
  output logic [1:0]  hyst,
  output logic [15:0] upperLim,
  output logic [15:0] lowerLim,
  output logic [15:0] critLim
);
  logic [7:0]  ptr;
  logic [15:0] wd, cfgWord;
  logic        anyLock;

  assign wd      = strobe.data;
  assign anyLock = alarmLock | critLock;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      ptr       <= '0;
      cfgEvt    <= '0;
      alarmLock <= 1'b0;
      critLock  <= 1'b0;
      shutdown  <= 1'b0;
      hyst      <= '0;
      upperLim  <= '0;
      lowerLim  <= '0;
      critLim   <= '0;
    end else begin
      if (strobe.ptrWr) ptr <= wd[7:0];
      if (strobe.regWr) begin
        case (ptr[2:0])
          SEL_CFG: begin
            if (!anyLock) begin
              cfgEvt   <= wd[3:0];
              shutdown <= wd[8];
            end else shutdown <= shutdown & wd[8];
            hyst      <= wd[10:9];
            alarmLock <= alarmLock | wd[6];
            critLock  <= critLock | wd[7];
          end
          SEL_UPR:  if (!alarmLock) upperLim <= wd & LIM_MASK;
          SEL_LWR:  if (!alarmLock) lowerLim <= wd & LIM_MASK;
          SEL_CRIT: if (!critLock)  critLim  <= wd & LIM_MASK;
          default: ;
        endcase
      end
    end

  assign cfgWord = {5'b0, hyst, shutdown, critLock, alarmLock, 2'b00, cfgEvt};

  always_comb begin
    unique case (ptr[2:0])
      SEL_CAP:  rdData = CAP_VALUE;
      SEL_CFG:  rdData = cfgWord;
      SEL_UPR:  rdData = upperLim;
      SEL_LWR:  rdData = lowerLim;
      SEL_CRIT: rdData = critLim;
      SEL_TEMP: rdData = tempValue;
      SEL_MFR:  rdData = MFR_ID;
      default:  rdData = DEV_ID;
    endcase
  end
endmodule

// File: rtl/smb_ptr_regfile.sv
module smb_ptr_regfile
  import smb_pkg::*;
#(
  parameter int          SYNC_STAGES    = 2,
  parameter int          TIMEOUT_CYCLES = 15_000_000,
  parameter logic [15:0] CAP_VALUE      = 16'h001D,
  parameter logic [15:0] MFR_ID         = 16'h11D4,
  parameter logic [15:0] DEV_ID         = 16'h0801
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [2:0]  addrPins,
  input  logic [15:0] tempValue,
  output logic        sdaOe,
  output logic        busBusy,
  output logic        evtMode,
  output logic        evtPol,
  output logic        critOnly,
  output logic        evtEnable,
  output logic        alarmLock,
  output logic        critLock,
  output logic        shutdown,
  output logic [1:0]  hyst,
  output logic [15:0] upperLim,
  output logic [15:0] lowerLim,
  output logic [15:0] critLim
);
  smbStrobe_t  strobe;
  logic [15:0] rdData;
  logic [3:0]  cfgEvt;

  smb_bus_ctrl #(.SYNC_STAGES(SYNC_STAGES), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .addrPins(addrPins),
    .rdData(rdData), .strobe(strobe), .sdaOe(sdaOe), .busBusy(busBusy)
  );

  smb_reg_dp #(.CAP_VALUE(CAP_VALUE), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tempValue(tempValue), .rdData(rdData),
    .cfgEvt(cfgEvt), .alarmLock(alarmLock), .critLock(critLock), .shutdown(shutdown),
    .hyst(hyst), .upperLim(upperLim), .lowerLim(lowerLim), .critLim(critLim)
  );

  assign evtMode   = cfgEvt[0];
  assign evtPol    = cfgEvt[1];
  assign critOnly  = cfgEvt[2];
  assign evtEnable = cfgEvt[3];
endmodule

// File: rtl/smb_ptr_regfile_chk.sv
module smb_ptr_regfile_chk (
  input logic        clk,
  input logic        rstN,
  input logic        sdaOe,
  input logic        busBusy,
  input logic        evtMode,
  input logic        evtPol,
  input logic        critOnly,
  input logic        evtEnable,
  input logic        alarmLock,
  input logic        critLock,
  input logic        shutdown,
  input logic [15:0] upperLim,
  input logic [15:0] lowerLim,
  input logic [15:0] critLim
);
  a_r14_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    !busBusy |-> !sdaOe);

  a_r9_limit_bits: assert property (@(posedge clk) disable iff (!rstN)
    ((upperLim | lowerLim | critLim) & ~16'h1FFC) == 16'h0000);

  a_r10_alarm_frozen: assert property (@(posedge clk) disable iff (!rstN)
    alarmLock |=> ($stable(upperLim) && $stable(lowerLim)));

  a_r10_crit_frozen: assert property (@(posedge clk) disable iff (!rstN)
    critLock |=> $stable(critLim));

  a_r11_locks_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (alarmLock || critLock) |=> ($past(alarmLock) <= alarmLock) && ($past(critLock) <= critLock));

  a_r11_event_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (alarmLock || critLock) |=> $stable({evtMode, evtPol, critOnly, evtEnable}));

  a_r11_no_shutdown_set: assert property (@(posedge clk) disable iff (!rstN)
    ((alarmLock || critLock) && !shutdown) |=> !shutdown);
endmodule

bind smb_ptr_regfile smb_ptr_regfile_chk u_chk (.*);

// File: tb/smb_ptr_regfile_tb.sv
`timescale 1ns/1ps
module smb_ptr_regfile_tb;
  localparam int TMO = 3000;
  localparam int Q   = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [2:0]  addrPins = 3'b101;
  logic [15:0] tempValue = 16'h0000;
  logic sdaOe, busBusy, evtMode, evtPol, critOnly, evtEnable;
  logic alarmLock, critLock, shutdown;
  logic [1:0]  hyst;
  logic [15:0] upperLim, lowerLim, critLim;
  logic sdaLine;

  assign sdaLine = sdaM & ~sdaOe;
  always #2.5 clk = ~clk;

  smb_ptr_regfile #(.TIMEOUT_CYCLES(TMO)) u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .addrPins(addrPins),
    .tempValue(tempValue), .sdaOe(sdaOe), .busBusy(busBusy), .evtMode(evtMode),
    .evtPol(evtPol), .critOnly(critOnly), .evtEnable(evtEnable), .alarmLock(alarmLock),
    .critLock(critLock), .shutdown(shutdown), .hyst(hyst), .upperLim(upperLim),
    .lowerLim(lowerLim), .critLim(critLim)
  );

  int nChk = 0, nBad = 0;
  bit done = 0;
  logic [15:0] expQ[$], obsQ[$];
  string tagQ[$];

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (obsQ.size() != 0 && expQ.size() != 0) begin
      logic [15:0] o, e;
      string t;
      o = obsQ.pop_front();
      e = expQ.pop_front();
      t = tagQ.pop_front();
      chk(o, e, t);
    end
  end

  task automatic qdel();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; qdel(); sclM = 1'b1; qdel(); sdaM = 1'b0; qdel(); sclM = 1'b0; qdel();
  endtask

  task automatic busStop();
    sdaM = 1'b0; qdel(); sclM = 1'b1; qdel(); sdaM = 1'b1; qdel();
  endtask

  task automatic putBit(input logic b);
    sdaM = b; qdel(); sclM = 1'b1; qdel(); qdel(); sclM = 1'b0; qdel();
  endtask

  task automatic getBit(output logic b);
    sdaM = 1'b1; qdel(); sclM = 1'b1; qdel(); b = sdaLine; qdel(); sclM = 1'b0; qdel();
  endtask

  task automatic putByte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    getBit(b);
    ack = ~b;
  endtask

  task automatic getByte(output logic [7:0] v, input logic mAck);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      v[i] = b;
    end
    putBit(~mAck);
  endtask

  task automatic wrReg(input logic [2:0] p, input logic [15:0] v, input int extra, input string tag);
    logic a;
    busStart();
    putByte(8'h3A, a); chk({15'd0, a}, 16'd1, {tag, " addr ack"});
    putByte({5'd0, p}, a); chk({15'd0, a}, 16'd1, {tag, " ptr ack"});
    putByte(v[15:8], a); chk({15'd0, a}, 16'd1, {tag, " hi ack"});
    putByte(v[7:0], a); chk({15'd0, a}, 16'd1, {tag, " lo ack"});
    for (int i = 0; i < extra; i++) begin
      putByte(8'hFF, a); chk({15'd0, a}, 16'd1, {tag, " extra ack"});
    end
    busStop();
  endtask

  task automatic rdWord(input logic useRs, input logic [2:0] p, input logic [15:0] e,
                        input logic lastAck, input string tag);
    logic a;
    logic [7:0] hi, lo;
    expQ.push_back(e);
    tagQ.push_back(tag);
    busStart();
    if (useRs) begin
      putByte(8'h3A, a); chk({15'd0, a}, 16'd1, {tag, " addr ack"});
      putByte({5'd0, p}, a); chk({15'd0, a}, 16'd1, {tag, " ptr ack"});
      busStart();
    end
    putByte(8'h3B, a); chk({15'd0, a}, 16'd1, {tag, " read addr ack"});
    getByte(hi, 1'b1);
    getByte(lo, lastAck);
    chk({15'd0, sdaOe}, 16'd0, {tag, " R5 released after last byte"});
    busStop();
    obsQ.push_back({hi, lo});
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic a;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    // R6, R14: reset state
    chk({15'd0, sdaOe}, 16'd0, "R14 reset sdaOe");
    chk({15'd0, busBusy}, 16'd0, "R14 reset busy");
    chk(upperLim | lowerLim | critLim, 16'd0, "R6 reset limits");
    chk({7'd0, hyst, shutdown, critLock, alarmLock, evtEnable, critOnly, evtPol, evtMode}, 16'd0, "R6 reset cfg");
    // R1: foreign address not acknowledged
    busStart(); putByte(8'hA0, a); chk({15'd0, a}, 16'd0, "R1 foreign nack"); busStop();
    // R2, R6: read without pointer write gives capability
    rdWord(1'b0, 3'd0, 16'h001D, 1'b0, "R2 default ptr capability");
    // R8: second matching transfer freezes pins
    busStart(); putByte(8'h3A, a); chk({15'd0, a}, 16'd1, "R1 own addr ack");
    putByte(8'h06, a); busStop();
    addrPins = 3'b000;
    rdWord(1'b0, 3'd6, 16'h11D4, 1'b1, "R2 ptr hold R8 frozen R5 ack-last");
    busStart(); putByte(8'h30, a); chk({15'd0, a}, 16'd0, "R8 new pins ignored"); busStop();
    // R4: repeated start read
    rdWord(1'b1, 3'd7, 16'h0801, 1'b0, "R4 rs read dev id R6");
    // R9: limit masking
    wrReg(3'd2, 16'hFFFF, 0, "R9");
    rdWord(1'b1, 3'd2, 16'h1FFC, 1'b0, "R9 upper mask");
    chk(upperLim, 16'h1FFC, "R9 upperLim port");
    wrReg(3'd3, 16'h0123, 0, "R9");
    rdWord(1'b1, 3'd3, 16'h0120, 1'b0, "R9 lower mask");
    wrReg(3'd4, 16'h0A5F, 0, "R9");
    rdWord(1'b1, 3'd4, 16'h0A5C, 1'b0, "R9 crit mask");
    // R3: MSB first, extra bytes ignored
    wrReg(3'd1, 16'h0601, 2, "R3");
    rdWord(1'b1, 3'd1, 16'h0601, 1'b0, "R3 cfg extra ignored");
    chk({14'd0, hyst}, 16'd3, "R3 hyst port");
    chk({15'd0, evtMode}, 16'd1, "R3 evtMode port");
    // R12
    wrReg(3'd1, 16'h0631, 0, "R12");
    rdWord(1'b1, 3'd1, 16'h0601, 1'b0, "R12 clear and status read 0");
    // R13
    wrReg(3'd0, 16'h1234, 0, "R13");
    rdWord(1'b1, 3'd0, 16'h001D, 1'b0, "R13 capability unchanged");
    tempValue = 16'h0C90;
    wrReg(3'd5, 16'hFFFF, 0, "R13");
    rdWord(1'b1, 3'd5, 16'h0C90, 1'b0, "R13 temperature unchanged");
    wrReg(3'd6, 16'h0000, 0, "R13");
    rdWord(1'b1, 3'd6, 16'h11D4, 1'b0, "R13 mfr id unchanged");
    // R11
    wrReg(3'd1, 16'h0100, 0, "R11");
    rdWord(1'b1, 3'd1, 16'h0100, 1'b0, "R11 shutdown set unlocked");
    wrReg(3'd1, 16'h0140, 0, "R11");
    rdWord(1'b1, 3'd1, 16'h0140, 1'b0, "R11 alarm lock set");
    wrReg(3'd1, 16'h000F, 0, "R11");
    rdWord(1'b1, 3'd1, 16'h0040, 1'b0, "R11 evt frozen shutdown cleared lock sticky");
    wrReg(3'd1, 16'h0100, 0, "R11");
    rdWord(1'b1, 3'd1, 16'h0040, 1'b0, "R11 shutdown set blocked");
    wrReg(3'd1, 16'h0600, 0, "R11");
    rdWord(1'b1, 3'd1, 16'h0640, 1'b0, "R11 hyst writable");
    // R10
    wrReg(3'd2, 16'h0100, 0, "R10");
    rdWord(1'b1, 3'd2, 16'h1FFC, 1'b0, "R10 upper locked");
    wrReg(3'd3, 16'h0000, 0, "R10");
    rdWord(1'b1, 3'd3, 16'h0120, 1'b0, "R10 lower locked");
    wrReg(3'd4, 16'h0500, 0, "R10");
    rdWord(1'b1, 3'd4, 16'h0500, 1'b0, "R10 crit open under alarm lock");
    wrReg(3'd1, 16'h0080, 0, "R10");
    rdWord(1'b1, 3'd1, 16'h00C0, 1'b0, "R10 both locks");
    wrReg(3'd4, 16'h0700, 0, "R10");
    rdWord(1'b1, 3'd4, 16'h0500, 1'b0, "R10 crit locked");
    // R7: timeout while driving ACK
    busStart();
    for (int i = 7; i >= 0; i--) putBit(8'h3A >> i);
    sdaM = 1'b1; qdel();
    chk({15'd0, sdaOe}, 16'd1, "R7 ack driven before timeout");
    chk({15'd0, busBusy}, 16'd1, "R14 busy in transfer");
    repeat (TMO + 20) @(negedge clk);
    chk({15'd0, sdaOe}, 16'd0, "R7 sda released");
    chk({15'd0, busBusy}, 16'd0, "R7 busy cleared");
    sclM = 1'b1; qdel();
    rdWord(1'b0, 3'd4, 16'h0500, 1'b0, "R7 recovered read");
    repeat (20) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule